// File: doc/BRIEF.md
# Oversampling Modulator Clock, Sync and Flag Sequencer

This block holds the digital timing and status logic of one channel of a one-bit oversampling modulator. It divides the master clock by a fixed ratio to produce the sample rate. It launches one output bit per sample period from a behavioural bit input. The ratio is four by default, so 2.048 MHz gives a 512 kHz bit stream and 1.024 MHz gives 256 kHz. A rising edge on the sync input is captured on the falling master-clock edge. It re-zeroes the divider so that sampling always falls on the same master-clock phase.

The block also owns the stability flag. A digitized trip indication, meaning the input is more than 5 percent beyond full scale in either polarity, raises the flag. The flag falls only after a run of consecutive in-range master clocks, 32 by default. A per-channel power-down input, and a loss-of-clock detector that runs on a free-running reference clock, both force the channel into standby. In standby the bit output and the flag are low, and the divider waits at phase zero.

Top module: `dsm_sync_flag_seq`

## Requirements
- R1: With the channel active, a bit is launched every 4 master-clock rising edges, and `bitStrobe` is high for the one cycle after each launch edge.
- R2: `dataOut` takes the value of `bitIn` sampled at a launch edge and holds it unchanged until the next launch edge.
- R3: A low-to-high change of `syncIn` is captured on a falling master-clock edge. On the next rising edge the divider returns to phase zero and, once the channel is armed, a bit is launched there. Later launches follow every 4 edges from that point.
- R4: Holding `syncIn` high causes no further realignment; launches continue every 4 edges.
- R5: `flagOut` goes high after the first rising edge that samples `beyondFs` = 1.
- R6: Once raised, `flagOut` falls after the 32nd consecutive rising edge that samples `insideFs` = 1 and `beyondFs` = 0.
- R7: An edge that samples `insideFs` = 0, or `beyondFs` = 1, while the flag is high restarts the count of R6 from zero.
- R8: While `pwrDown` = 1, after the next rising edge `dataOut`, `flagOut` and `bitStrobe` are 0 and `standby` is 1. `bitIn`, `syncIn` and `beyondFs` have no effect; no launch or flag survives the release.
- R9: After standby ends, the first launch happens on the 4th rising edge. A sync edge inside that first period re-zeroes the phase without launching, so the first launch moves to the 4th edge after the sync.
- R10: When the master clock stops for 16 reference-clock cycles, `dataOut` and `flagOut` are forced to 0 and `standby` goes high. Before that they keep their values.
- R11: When master-clock edges return, the channel leaves standby and the divider restarts from phase zero. No launch occurs in the first 4 edges after the restart.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| refClk | input | 1 | Free-running reference clock for the loss-of-clock detector |
| rstN | input | 1 | Asynchronous reset, active low |
| syncIn | input | 1 | Sync strobe, rising edge realigns the divider |
| pwrDown | input | 1 | Channel power-down request, synchronous to mclk |
| beyondFs | input | 1 | Input more than 5 percent beyond full scale (trip) |
| insideFs | input | 1 | Input within full scale |
| bitIn | input | 1 | Behavioural modulator bit to launch |
| dataOut | output | 1 | Launched output bit |
| flagOut | output | 1 | Stability flag |
| bitStrobe | output | 1 | One-cycle pulse after each launch |
| standby | output | 1 | Channel held in standby |

## Verification
The divider is tried with free running, a sync edge placed mid-period, and a sync held high. These separate true realignment from an unchanged phase and from a sync that re-triggers on level. The flag is driven by a single trip followed by a clean run, and then by runs broken by an out-of-window cycle or a fresh trip. Checks on both sides of the 32nd edge expose off-by-one and non-restarting counters. Power-down is exercised with noisy bit, sync and trip inputs, and with a sync right at release. A stopped master clock is probed before and after the loss threshold, and again on restart, to show the forced standby, the release and the phase-zero restart.

// File: rtl/dsm_seq_pkg.sv
package dsm_seq_pkg;

  // Strobes from control to datapath, one per mclk cycle
  typedef struct packed {
    logic launch;   // load bitIn into the output register
    logic hold;     // channel in standby
    logic flagSet;  // trip seen
    logic flagClr;  // recovery run complete
  } seqStrobe_t;

endpackage

// File: rtl/dsm_clk_watch.sv
module dsm_clk_watch #(
  parameter int LOSS_LIMIT = 16
) (
  input  logic mclk,
  input  logic refClk,
  input  logic rstN,
  output logic lostRef,
  output logic runN
);

  localparam int LW = $clog2(LOSS_LIMIT + 1);

  logic       mclkTog;
  logic [2:0] togSync;
  logic [LW-1:0] stallCnt;
  logic       edgeSeen;
  logic       holdN;
  logic [1:0] runSync;

  // Toggles on every master-clock edge
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) mclkTog <= 1'b0;
    else       mclkTog <= ~mclkTog;
  end

  assign edgeSeen = togSync[1] ^ togSync[2];

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      togSync  <= '0;
      stallCnt <= '0;
      lostRef  <= 1'b0;
    end else begin
      togSync <= {togSync[1:0], mclkTog};
      if (edgeSeen) begin
        stallCnt <= '0;
        lostRef  <= 1'b0;
      end else if (stallCnt == LW'(LOSS_LIMIT - 1)) begin
        lostRef <= 1'b1;
      end else begin
        stallCnt <= stallCnt + 1'b1;
      end
    end
  end

  // Run enable for the mclk domain: asserted low at once, released after two edges
  assign holdN = rstN & ~lostRef;

  always_ff @(posedge mclk or negedge holdN) begin
    if (!holdN) runSync <= 2'b00;
    else        runSync <= {runSync[0], 1'b1};
  end

  assign runN = runSync[1];

  AST_LOST_RELEASE: assert property (@(posedge refClk) disable iff (!rstN)
    edgeSeen |=> !lostRef);  // R11
  AST_LOST_AFTER_LIMIT: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lostRef) |-> (stallCnt == LW'(LOSS_LIMIT - 1)));  // R10

endmodule

// File: rtl/dsm_seq_ctrl.sv
module dsm_seq_ctrl
  import dsm_seq_pkg::*;
#(
  parameter int DIV_RATIO      = 4,
  parameter int RECOVER_CYCLES = 32
) (
  input  logic       mclk,
  input  logic       rstN,
  input  logic       runN,
  input  logic       syncIn,
  input  logic       pwrDown,
  input  logic       beyondFs,
  input  logic       insideFs,
  output seqStrobe_t strobe
);

  localparam int PW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam int CW = (RECOVER_CYCLES > 2) ? $clog2(RECOVER_CYCLES) : 1;

  logic          syncCap;
  logic          syncPrev;
  logic          syncRise;
  logic [PW-1:0] phase;
  logic          armed;
  logic          recovering;
  logic [CW-1:0] recCnt;
  logic          hold;
  logic          naturalHit;
  logic          inWin;
  logic          runDone;

  // Sync sampled on the falling edge; the edge pulse spans the next rising edge
  always_ff @(negedge mclk or negedge rstN) begin
    if (!rstN) begin
      syncCap  <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncCap  <= syncIn;
      syncPrev <= syncCap;
    end
  end

  assign syncRise   = syncCap & ~syncPrev;
  assign hold       = pwrDown | ~runN;
  assign naturalHit = (phase == PW'(DIV_RATIO - 1));
  assign inWin      = insideFs & ~beyondFs;
  assign runDone    = (recCnt == CW'(RECOVER_CYCLES - 1));

  always_comb begin
    strobe.hold    = hold;
    strobe.launch  = !hold && (naturalHit || (syncRise && armed));
    strobe.flagSet = !hold && beyondFs;
    strobe.flagClr = !hold && recovering && inWin && runDone;
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      phase      <= '0;
      armed      <= 1'b0;
      recovering <= 1'b0;
      recCnt     <= '0;
    end else if (hold) begin
      phase      <= '0;
      armed      <= 1'b0;
      recovering <= 1'b0;
      recCnt     <= '0;
    end else begin
      if (syncRise || naturalHit) phase <= '0;
      else                        phase <= phase + 1'b1;
      if (naturalHit) armed <= 1'b1;

      if (beyondFs) begin
        recovering <= 1'b1;
        recCnt     <= '0;
      end else if (recovering) begin
        if (!inWin) begin
          recCnt <= '0;
        end else if (runDone) begin
          recovering <= 1'b0;
          recCnt     <= '0;
        end else begin
          recCnt <= recCnt + 1'b1;
        end
      end
    end
  end

  AST_HOLD_PHASE_ZERO: assert property (@(posedge mclk) disable iff (!rstN)
    hold |=> (phase == '0));  // R8
  AST_SYNC_REALIGN: assert property (@(posedge mclk) disable iff (!rstN)
    (syncRise && !hold) |=> (phase == '0));  // R3
  AST_CLEAR_IN_WINDOW: assert property (@(posedge mclk) disable iff (!rstN)
    strobe.flagClr |-> (insideFs && !beyondFs));  // R6

endmodule

// File: rtl/dsm_seq_data.sv
module dsm_seq_data
  import dsm_seq_pkg::*;
(
  input  logic       mclk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       bitIn,
  output logic       dataQ,
  output logic       flagQ,
  output logic       pulseQ
);

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= 1'b0;
      flagQ  <= 1'b0;
      pulseQ <= 1'b0;
    end else if (strobe.hold) begin
      dataQ  <= 1'b0;
      flagQ  <= 1'b0;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= strobe.launch;
      if (strobe.launch) dataQ <= bitIn;
      if (strobe.flagSet)      flagQ <= 1'b1;
      else if (strobe.flagClr) flagQ <= 1'b0;
    end
  end

  AST_DATA_HELD: assert property (@(posedge mclk) disable iff (!rstN)
    (!strobe.launch && !strobe.hold) |=> $stable(dataQ));  // R2
  AST_FLAG_RAISE: assert property (@(posedge mclk) disable iff (!rstN)
    strobe.flagSet |=> flagQ);  // R5
  AST_STANDBY_LOW: assert property (@(posedge mclk) disable iff (!rstN)
    strobe.hold |=> (!dataQ && !flagQ && !pulseQ));  // R8

endmodule

// File: rtl/dsm_sync_flag_seq.sv
module dsm_sync_flag_seq
  import dsm_seq_pkg::*;
#(
  parameter int DIV_RATIO      = 4,
  parameter int RECOVER_CYCLES = 32,
  parameter int LOSS_LIMIT     = 16
) (
  input  logic mclk,
  input  logic refClk,
  input  logic rstN,
  input  logic syncIn,
  input  logic pwrDown,
  input  logic beyondFs,
  input  logic insideFs,
  input  logic bitIn,
  output logic dataOut,
  output logic flagOut,
  output logic bitStrobe,
  output logic standby
);

  seqStrobe_t strobe;
  logic       lostRef;
  logic       runN;
  logic       dataQ;
  logic       flagQ;
  logic       pulseQ;

  dsm_clk_watch #(.LOSS_LIMIT(LOSS_LIMIT)) uWatch (
    .mclk    (mclk),
    .refClk  (refClk),
    .rstN    (rstN),
    .lostRef (lostRef),
    .runN    (runN)
  );

  dsm_seq_ctrl #(
    .DIV_RATIO      (DIV_RATIO),
    .RECOVER_CYCLES (RECOVER_CYCLES)
  ) uCtrl (
    .mclk     (mclk),
    .rstN     (rstN),
    .runN     (runN),
    .syncIn   (syncIn),
    .pwrDown  (pwrDown),
    .beyondFs (beyondFs),
    .insideFs (insideFs),
    .strobe   (strobe)
  );

  dsm_seq_data uData (
    .mclk   (mclk),
    .rstN   (rstN),
    .strobe (strobe),
    .bitIn  (bitIn),
    .dataQ  (dataQ),
    .flagQ  (flagQ),
    .pulseQ (pulseQ)
  );

  // A stopped clock cannot clear registers, so gate with the reference-domain loss bit
  assign dataOut   = dataQ  & ~lostRef;
  assign flagOut   = flagQ  & ~lostRef;
  assign bitStrobe = pulseQ & ~lostRef;
  assign standby   = pwrDown | ~runN | lostRef;

endmodule

// File: tb/tb_dsm_sync_flag_seq.sv
`timescale 1ns/1ps
module tb_dsm_sync_flag_seq;

  logic osc = 1'b0;
  logic clkRun = 1'b1;
  logic refClk = 1'b0;
  logic mclk;
  logic rstN, syncIn, pwrDown, beyondFs, insideFs, bitIn;
  logic dataOut, flagOut, bitStrobe, standby;
  int   checks = 0;
  int   failures = 0;

  always #5 osc = ~osc;
  always #3 refClk = ~refClk;
  assign mclk = osc & clkRun;

  dsm_sync_flag_seq dut (
    .mclk(mclk), .refClk(refClk), .rstN(rstN), .syncIn(syncIn),
    .pwrDown(pwrDown), .beyondFs(beyondFs), .insideFs(insideFs),
    .bitIn(bitIn), .dataOut(dataOut), .flagOut(flagOut),
    .bitStrobe(bitStrobe), .standby(standby)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge mclk);
    #2;
  endtask

  task automatic waitStrobe(input int maxEdges, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!bitStrobe && n < maxEdges);
  endtask

  task automatic testReset();
    rstN = 1'b0; syncIn = 0; pwrDown = 0; beyondFs = 0; insideFs = 1; bitIn = 0;
    repeat (3) @(posedge osc);
    #2;
    check(!dataOut && !flagOut && !bitStrobe, "R12 reset outputs", {dataOut, flagOut, bitStrobe}, 0);
    rstN = 1'b1;
  endtask

  task automatic testPeriod();
    int n;
    waitStrobe(16, n);
    check(bitStrobe == 1'b1, "R1 first strobe", bitStrobe, 1);
    for (int k = 0; k < 2; k++) begin
      waitStrobe(16, n);
      check(n == 4, "R1 launch spacing", n, 4);
    end
  endtask

  task automatic testData();
    int n;
    bitIn = 1'b0;
    waitStrobe(8, n);
    bitIn = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      tick();
      check(dataOut == 1'b0, "R2 held between launches", dataOut, 0);
    end
    tick();
    check(dataOut == 1'b1 && bitStrobe, "R2 bit loaded at launch", dataOut, 1);
    bitIn = 1'b0;
    repeat (3) tick();
    check(dataOut == 1'b1, "R2 held after input change", dataOut, 1);
    tick();
    check(dataOut == 1'b0, "R2 new bit at launch", dataOut, 0);
  endtask

  task automatic testSync();
    int n;
    waitStrobe(8, n);
    tick();
    syncIn = 1'b1;
    bitIn = 1'b1;
    tick();
    check(bitStrobe == 1'b1, "R3 launch on edge after sync", bitStrobe, 1);
    check(dataOut == 1'b1, "R3 realigned bit value", dataOut, 1);
    tick(); tick();
    check(bitStrobe == 1'b0, "R3 old phase launch removed", bitStrobe, 0);
    tick(); tick();
    check(bitStrobe == 1'b1, "R3 new phase launch", bitStrobe, 1);
    repeat (4) tick();
    check(bitStrobe == 1'b1, "R4 sync held high keeps period", bitStrobe, 1);
    waitStrobe(8, n);
    check(n == 4, "R4 no retrigger", n, 4);
    syncIn = 1'b0;
    bitIn = 1'b0;
  endtask

  task automatic testFlagBasic();
    beyondFs = 1'b1; insideFs = 1'b0;
    tick();
    check(flagOut == 1'b1, "R5 flag raised on trip", flagOut, 0 + 1);
    beyondFs = 1'b0; insideFs = 1'b1;
    repeat (31) tick();
    check(flagOut == 1'b1, "R6 flag held after 31 in-range", flagOut, 1);
    tick();
    check(flagOut == 1'b0, "R6 flag clears at 32", flagOut, 0);
  endtask

  task automatic testFlagRestart();
    beyondFs = 1'b1; insideFs = 1'b0;
    tick();
    beyondFs = 1'b0; insideFs = 1'b1;
    repeat (20) tick();
    insideFs = 1'b0;
    tick();
    insideFs = 1'b1;
    repeat (31) tick();
    check(flagOut == 1'b1, "R7 out-of-window restarts count", flagOut, 1);
    repeat (5) tick();
    beyondFs = 1'b1;
    tick();
    beyondFs = 1'b0;
    repeat (31) tick();
    check(flagOut == 1'b1, "R7 trip restarts count", flagOut, 1);
    tick();
    check(flagOut == 1'b0, "R7 clears after full run", flagOut, 0);
  endtask

  task automatic testPowerDown();
    int bad = 0;
    bitIn = 1'b1;
    beyondFs = 1'b1;
    tick();
    beyondFs = 1'b0;
    pwrDown = 1'b1;
    tick();
    check(!dataOut && !flagOut && !bitStrobe && standby, "R8 outputs low in power-down",
          {dataOut, flagOut, bitStrobe, standby}, 1);
    for (int k = 0; k < 10; k++) begin
      syncIn = k[0];
      beyondFs = 1'b1;
      tick();
      if (dataOut || flagOut || bitStrobe) bad++;
    end
    check(bad == 0, "R8 inputs ignored in power-down", bad, 0);
    syncIn = 1'b0; beyondFs = 1'b0;
    tick();
    pwrDown = 1'b0;
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      if (bitStrobe) bad++;
    end
    check(bad == 0, "R9 no launch in first period", bad, 0);
    tick();
    check(bitStrobe == 1'b1 && dataOut == 1'b1, "R9 first launch on 4th edge", bitStrobe, 1);
    check(flagOut == 1'b0, "R8 trip in power-down dropped", flagOut, 0);
  endtask

  task automatic testPowerDownSync();
    int bad = 0;
    pwrDown = 1'b1;
    tick(); tick();
    pwrDown = 1'b0;
    syncIn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      if (bitStrobe) bad++;
    end
    check(bad == 0, "R9 sync in first period gives no launch", bad, 0);
    tick();
    check(bitStrobe == 1'b1, "R9 launch 4 edges after sync", bitStrobe, 1);
    syncIn = 1'b0;
  endtask

  task automatic testClockLoss();
    int n;
    int bad = 0;
    bitIn = 1'b1;
    waitStrobe(8, n);
    beyondFs = 1'b1;
    tick();
    beyondFs = 1'b0;
    check(dataOut && flagOut, "R10 setup data and flag high", {dataOut, flagOut}, 3);
    #4 clkRun = 1'b0;
    #30;
    check(dataOut && flagOut && !standby, "R10 no action before limit",
          {dataOut, flagOut, standby}, 6);
    #200;
    check(!dataOut && !flagOut && standby, "R10 forced standby on lost clock",
          {dataOut, flagOut, standby}, 1);
    @(negedge osc);
    clkRun = 1'b1;
    tick();
    check(dataOut == 1'b0, "R11 output low on restart", dataOut, 0);
    if (bitStrobe) bad++;
    for (int k = 0; k < 3; k++) begin
      tick();
      if (bitStrobe) bad++;
    end
    check(bad == 0, "R11 no early launch after restart", bad, 0);
    waitStrobe(16, n);
    check(bitStrobe == 1'b1 && !standby, "R11 channel resumes", bitStrobe, 1);
    check(flagOut == 1'b0, "R11 flag cleared by loss", flagOut, 0);
  endtask

  initial begin
    repeat (100000) @(posedge osc);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testPeriod();
    testData();
    testSync();
    testFlagBasic();
    testFlagRestart();
    testPowerDown();
    testPowerDownSync();
    testClockLoss();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule